// File: doc/BRIEF.md
# I2C SCL and SDA Timing Generator

This block is the bit-timing engine of an I2C master. It turns programmable counts of the controller clock into an SCL waveform. It also produces two single-cycle strobes: one tells the shifter when to put the next SDA bit on the line, and one tells it when to sample SDA. Byte sequencing, acknowledge handling and data buffering sit outside the block. They issue one command at a time (START, one bit clock, or STOP) and wait for `cmd_ready`.

Two pairs of high and low counts are held at the ports, one pair for standard mode and one for fast mode, and a two-bit speed field picks one pair. The high count never drops below 6 and the low count never below 8. A nine-bit hold field sets how far behind the falling SCL edge the drive strobe lands. Its top bit enables the delay and its low byte is the count. An eight-bit setup field sets the quiet time before the rising edge. All of these values are captured when a START is accepted and stay fixed until the next START. While SCL is released, the high phase counts only the cycles in which the sampled line is actually high, so a device that holds SCL low stretches the clock.

States: IDLE; BIT_LOW and BIT_HIGH (bit clock); RS_LOW and RS_HIGH (bus brought back to released before a repeated START); ST_HOLD (START hold with SDA pulled low); SP_LOW and SP_HIGH (STOP). The transitions are:
- IDLE→ST_HOLD on START with the bus free.
- IDLE→RS_LOW on START with the bus held.
- IDLE→BIT_LOW on a bit command with the bus held.
- IDLE→SP_LOW on STOP with the bus held.
- BIT_LOW→BIT_HIGH, RS_LOW→RS_HIGH and SP_LOW→SP_HIGH when the low count expires.
- RS_HIGH→ST_HOLD, ST_HOLD→IDLE (bus held), BIT_HIGH→IDLE and SP_HIGH→IDLE (bus free) when the high count or setup count expires.
- Any state→IDLE with the bus free when `enable` is low.

Top module: `i2c_scl_timer`

## Requirements
- R1: After reset the block is idle with the bus free: `scl_out`=1, `sda_cond_low`=0 and both strobes 0. `cmd_ready` is 1 only while the block is idle and `enable` is 1.
- R2: The standard pair (`std_high`, `std_low`) is used unless `speed_sel` is 2'b10, which selects the fast pair (`fast_high`, `fast_low`).
- R3: The effective high count is max(selected high, 6). The effective low count is max(selected low, 8).
- R4: A bit command (`cmd_op`=1) holds SCL low for exactly the effective low count of cycles, then releases it.
- R5: In the low phase of a bit, `drive_stb` pulses once, at low-phase cycle (hold+1) when `hold_cfg[8]`=1. When `hold_cfg[8]`=0 it pulses at cycle 0. Low-phase cycles are counted from 0.
- R6: The drive cycle is clamped to at most (effective low − effective setup), or 0 if that is negative. This keeps at least (setup−1) low cycles after the drive strobe.
- R7: A released-SCL phase advances only on cycles with `scl_in`=1. The bit high phase therefore lasts (effective high + stretch) cycles, and `sample_stb` pulses once, on the first cycle in which `scl_in` is seen high.
- R8: START (`cmd_op`=0) with the bus free keeps SCL released with `sda_cond_low`=1 for the effective high count of counted cycles. It then holds SCL low while idle.
- R9: START with the bus held first runs one low phase and one released high phase with `sda_cond_low`=0, then performs the R8 hold.
- R10: STOP (`cmd_op`=2) runs a low phase with `sda_cond_low`=1. It then keeps SCL released with `sda_cond_low`=1 for the effective setup count max(`setup_cfg`,1) of counted cycles, then frees SDA and the bus.
- R11: Timing inputs are captured when a START is accepted. Changes made after that have no effect until the next START.
- R12: A bit or STOP command while the bus is free is accepted and ignored, and so is `cmd_op`=3. In both cases SCL and the strobes do not change.
- R13: With `enable` low, the next cycle shows SCL released and `sda_cond_low`=0, and the bus is marked free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low reset |
| enable | input | 1 | Controller enable; low aborts and frees the bus |
| speed_sel | input | 2 | 2'b10 selects the fast pair, other values the standard pair |
| std_high | input | 16 | Standard-mode SCL high count |
| std_low | input | 16 | Standard-mode SCL low count |
| fast_high | input | 16 | Fast-mode SCL high count |
| fast_low | input | 16 | Fast-mode SCL low count |
| hold_cfg | input | 9 | Bit 8 enables the hold delay; bits 7:0 are the hold count |
| setup_cfg | input | 8 | SDA setup count (0 treated as 1) |
| scl_in | input | 1 | Sampled SCL line level |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 0 START, 1 bit clock, 2 STOP, 3 no operation |
| cmd_ready | output | 1 | Idle and enabled; a command is taken when valid and ready |
| scl_out | output | 1 | 1 releases SCL, 0 pulls it low |
| sda_cond_low | output | 1 | Pull SDA low for a START or STOP condition |
| drive_stb | output | 1 | Put the next SDA bit on the line |
| sample_stb | output | 1 | Sample SDA now |

## Verification
Every output is decoded from registered state, so a command accepted at one rising edge shows its first phase cycle at the next sampling point. Each later phase cycle appears one clock after the one before it. The bench drives and samples on the falling edge and treats each falling-edge sample as one phase cycle. It counts low cycles, high cycles and condition cycles, and it records the indices at which the strobes appear until `cmd_ready` returns. These counts are compared with lengths computed from the captured settings. `sample_stb` follows `scl_in` within the same cycle, so the bench reads it shortly after setting `scl_in`. A disable is checked one sample after `enable` falls.

// File: rtl/i2c_tgen_pkg.sv
package i2c_tgen_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_BIT_LOW,
        S_BIT_HIGH,
        S_RS_LOW,
        S_RS_HIGH,
        S_ST_HOLD,
        S_SP_LOW,
        S_SP_HIGH
    } tgen_state_e;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_BIT   = 2'd1,
        OP_STOP  = 2'd2,
        OP_NONE  = 2'd3
    } tgen_op_e;

    localparam int HIGH_FLOOR = 6;
    localparam int LOW_FLOOR  = 8;
    localparam logic [1:0] SPEED_FAST = 2'b10;

endpackage

// File: rtl/i2c_tgen_cfg.sv
module i2c_tgen_cfg
    import i2c_tgen_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int SET_W  = 8,
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [1:0]        speed_sel,
    input  logic [CNT_W-1:0]  std_high,
    input  logic [CNT_W-1:0]  std_low,
    input  logic [CNT_W-1:0]  fast_high,
    input  logic [CNT_W-1:0]  fast_low,
    input  logic [HOLD_W:0]   hold_cfg,
    input  logic [SET_W-1:0]  setup_cfg,
    output logic [CNT_W-1:0]  hi_q,
    output logic [CNT_W-1:0]  lo_q,
    output logic [CNT_W-1:0]  su_q,
    output logic [CNT_W-1:0]  hd_q
);

    logic [CNT_W-1:0] pick_hi, pick_lo, hi_n, lo_n, su_n, hd_raw, hd_max, hd_n;

    always_comb begin
        pick_hi = (speed_sel == SPEED_FAST) ? fast_high : std_high;
        pick_lo = (speed_sel == SPEED_FAST) ? fast_low  : std_low;
        hi_n    = (pick_hi < CNT_W'(HIGH_FLOOR)) ? CNT_W'(HIGH_FLOOR) : pick_hi;
        lo_n    = (pick_lo < CNT_W'(LOW_FLOOR))  ? CNT_W'(LOW_FLOOR)  : pick_lo;
        su_n    = (setup_cfg == '0) ? CNT_W'(1) : CNT_W'(setup_cfg);
        hd_raw  = hold_cfg[HOLD_W] ? (CNT_W'(hold_cfg[HOLD_W-1:0]) + CNT_W'(1)) : '0;
        // keep the drive point early enough that (setup-1) low cycles remain
        hd_max  = (lo_n > su_n) ? (lo_n - su_n) : '0;
        hd_n    = (hd_raw > hd_max) ? hd_max : hd_raw;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= CNT_W'(HIGH_FLOOR);
            lo_q <= CNT_W'(LOW_FLOOR);
            su_q <= CNT_W'(1);
            hd_q <= '0;
        end else if (load) begin
            hi_q <= hi_n;
            lo_q <= lo_n;
            su_q <= su_n;
            hd_q <= hd_n;
        end
    end

endmodule

// File: rtl/i2c_tgen_ctr.sv
module i2c_tgen_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic [CNT_W-1:0] lim,
    output logic [CNT_W-1:0] cnt,
    output logic             last
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= cnt + CNT_W'(1);
    end

    assign last = (cnt == (lim - CNT_W'(1)));

endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer
    import i2c_tgen_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int SET_W  = 8,
    parameter int HOLD_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic [1:0]          speed_sel,
    input  logic [CNT_W-1:0]    std_high,
    input  logic [CNT_W-1:0]    std_low,
    input  logic [CNT_W-1:0]    fast_high,
    input  logic [CNT_W-1:0]    fast_low,
    input  logic [HOLD_W:0]     hold_cfg,
    input  logic [SET_W-1:0]    setup_cfg,
    input  logic                scl_in,
    input  logic                cmd_valid,
    input  logic [1:0]          cmd_op,
    output logic                cmd_ready,
    output logic                scl_out,
    output logic                sda_cond_low,
    output logic                drive_stb,
    output logic                sample_stb
);

    tgen_state_e state, nxt;
    logic held, held_nxt;
    logic cfg_load, cnt_clr, cnt_inc, cnt_last, advance;
    logic [CNT_W-1:0] hi_q, lo_q, su_q, hd_q, lim, cnt;

    i2c_tgen_cfg #(.CNT_W(CNT_W), .SET_W(SET_W), .HOLD_W(HOLD_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cfg_load),
        .speed_sel (speed_sel),
        .std_high  (std_high),
        .std_low   (std_low),
        .fast_high (fast_high),
        .fast_low  (fast_low),
        .hold_cfg  (hold_cfg),
        .setup_cfg (setup_cfg),
        .hi_q      (hi_q),
        .lo_q      (lo_q),
        .su_q      (su_q),
        .hd_q      (hd_q)
    );

    i2c_tgen_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .lim   (lim),
        .cnt   (cnt),
        .last  (cnt_last)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            held  <= 1'b0;
        end else if (!enable) begin
            state <= S_IDLE;
            held  <= 1'b0;
        end else begin
            state <= nxt;
            held  <= held_nxt;
        end
    end

    // phase limit and advance qualifier
    always_comb begin
        unique case (state)
            S_BIT_LOW, S_RS_LOW, S_SP_LOW: begin
                lim     = lo_q;
                advance = 1'b1;
            end
            S_BIT_HIGH, S_RS_HIGH, S_ST_HOLD: begin
                lim     = hi_q;
                advance = scl_in;
            end
            S_SP_HIGH: begin
                lim     = su_q;
                advance = scl_in;
            end
            default: begin
                lim     = lo_q;
                advance = 1'b0;
            end
        endcase
    end

    // next state
    always_comb begin
        nxt      = state;
        held_nxt = held;
        cfg_load = 1'b0;
        cnt_clr  = 1'b0;
        cnt_inc  = 1'b0;
        if (state == S_IDLE) begin
            cnt_clr = 1'b1;
            if (cmd_valid && enable) begin
                case (cmd_op)
                    OP_START: begin
                        cfg_load = 1'b1;
                        nxt      = held ? S_RS_LOW : S_ST_HOLD;
                    end
                    OP_BIT:  if (held) nxt = S_BIT_LOW;
                    OP_STOP: if (held) nxt = S_SP_LOW;
                    default: nxt = S_IDLE;
                endcase
            end
        end else if (advance) begin
            if (cnt_last) begin
                cnt_clr = 1'b1;
                unique case (state)
                    S_BIT_LOW:  nxt = S_BIT_HIGH;
                    S_BIT_HIGH: nxt = S_IDLE;
                    S_RS_LOW:   nxt = S_RS_HIGH;
                    S_RS_HIGH:  nxt = S_ST_HOLD;
                    S_ST_HOLD: begin
                        nxt      = S_IDLE;
                        held_nxt = 1'b1;
                    end
                    S_SP_LOW:   nxt = S_SP_HIGH;
                    S_SP_HIGH: begin
                        nxt      = S_IDLE;
                        held_nxt = 1'b0;
                    end
                    default:    nxt = S_IDLE;
                endcase
            end else begin
                cnt_inc = 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        cmd_ready    = 1'b0;
        scl_out      = 1'b1;
        sda_cond_low = 1'b0;
        drive_stb    = 1'b0;
        sample_stb   = 1'b0;
        unique case (state)
            S_IDLE: begin
                cmd_ready = enable;
                scl_out   = ~held;
            end
            S_BIT_LOW: begin
                scl_out   = 1'b0;
                drive_stb = (cnt == hd_q);
            end
            S_BIT_HIGH: sample_stb = scl_in && (cnt == '0);
            S_RS_LOW:   scl_out = 1'b0;
            S_RS_HIGH:  scl_out = 1'b1;
            S_ST_HOLD:  sda_cond_low = 1'b1;
            S_SP_LOW: begin
                scl_out      = 1'b0;
                sda_cond_low = 1'b1;
            end
            S_SP_HIGH:  sda_cond_low = 1'b1;
            default:    scl_out = 1'b1;
        endcase
    end

endmodule

// File: rtl/i2c_tgen_checker.sv
module i2c_tgen_checker (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic scl_in,
    input logic cmd_ready,
    input logic scl_out,
    input logic sda_cond_low,
    input logic drive_stb,
    input logic sample_stb
);

    a_r13_release_on_disable: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (scl_out && !sda_cond_low && !drive_stb));

    a_r5_drive_single: assert property (@(posedge clk) disable iff (!rst_n)
        drive_stb |=> !drive_stb);

    a_r5_drive_in_low: assert property (@(posedge clk) disable iff (!rst_n)
        drive_stb |-> !scl_out);

    a_r7_sample_when_high: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> (scl_out && scl_in));

    a_r7_sample_single: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> !sample_stb);

    a_r7_stretch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && scl_out && !scl_in && !cmd_ready) |=> scl_out);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (!sda_cond_low && !drive_stb && !sample_stb));

endmodule

bind i2c_scl_timer i2c_tgen_checker u_tgen_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .scl_in       (scl_in),
    .cmd_ready    (cmd_ready),
    .scl_out      (scl_out),
    .sda_cond_low (sda_cond_low),
    .drive_stb    (drive_stb),
    .sample_stb   (sample_stb)
);

// File: tb/test_i2c_scl_timer.sv
`timescale 1ns/1ps
module test_i2c_scl_timer;

    localparam logic [1:0] C_START = 2'd0, C_BIT = 2'd1, C_STOP = 2'd2, C_NONE = 2'd3;

    logic        clk = 1'b0, rst_n = 1'b0, enable = 1'b0;
    logic [1:0]  speed_sel = 2'b01;
    logic [15:0] std_high = 16'd20, std_low = 16'd30, fast_high = 16'd10, fast_low = 16'd12;
    logic [8:0]  hold_cfg = 9'h000;
    logic [7:0]  setup_cfg = 8'd1;
    logic        scl_in = 1'b1, cmd_valid = 1'b0;
    logic [1:0]  cmd_op = C_NONE;
    logic        cmd_ready, scl_out, sda_cond_low, drive_stb, sample_stb;

    int n_run = 0, n_fail = 0, stretch_left = 0;
    int m_lo, m_hi, m_drv_idx, m_drv_n, m_smp_idx, m_smp_n, m_cond;
    logic [1:0]  sv_speed;
    logic [15:0] sv_sh, sv_sl, sv_fh, sv_fl;
    logic [8:0]  sv_hold;
    logic [7:0]  sv_setup;
    bit done = 0;

    always #2.5 clk = ~clk;

    i2c_scl_timer i_i2c_scl_timer (
        .clk(clk), .rst_n(rst_n), .enable(enable), .speed_sel(speed_sel),
        .std_high(std_high), .std_low(std_low), .fast_high(fast_high), .fast_low(fast_low),
        .hold_cfg(hold_cfg), .setup_cfg(setup_cfg), .scl_in(scl_in),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_ready(cmd_ready),
        .scl_out(scl_out), .sda_cond_low(sda_cond_low),
        .drive_stb(drive_stb), .sample_stb(sample_stb));

    function automatic int x_hi();
        int v = (sv_speed == 2'b10) ? int'(sv_fh) : int'(sv_sh);
        return (v < 6) ? 6 : v;
    endfunction
    function automatic int x_lo();
        int v = (sv_speed == 2'b10) ? int'(sv_fl) : int'(sv_sl);
        return (v < 8) ? 8 : v;
    endfunction
    function automatic int x_su();
        return (sv_setup == 0) ? 1 : int'(sv_setup);
    endfunction
    function automatic int x_hd();
        int raw = sv_hold[8] ? int'(sv_hold[7:0]) + 1 : 0;
        int mx  = (x_lo() > x_su()) ? x_lo() - x_su() : 0;
        return (raw > mx) ? mx : raw;
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        scl_in = scl_out && !(stretch_left > 0 && !cmd_ready);
        if (scl_out && stretch_left > 0 && !cmd_ready) stretch_left--;
        #1;
    endtask

    task automatic run_cmd(logic [1:0] op, int s);
        while (!cmd_ready) step();
        stretch_left = s;
        cmd_valid = 1'b1;
        cmd_op = op;
        step();
        cmd_valid = 1'b0;
        m_lo = 0; m_hi = 0; m_drv_idx = -1; m_drv_n = 0; m_smp_idx = -1; m_smp_n = 0; m_cond = 0;
        while (!cmd_ready) begin
            if (!scl_out) begin
                if (drive_stb) begin m_drv_idx = m_lo; m_drv_n++; end
                m_lo++;
            end else begin
                if (sample_stb) begin m_smp_idx = m_hi; m_smp_n++; end
                m_hi++;
            end
            if (sda_cond_low) m_cond++;
            step();
        end
    endtask

    task automatic snap();
        sv_speed = speed_sel; sv_sh = std_high; sv_sl = std_low; sv_fh = fast_high;
        sv_fl = fast_low; sv_hold = hold_cfg; sv_setup = setup_cfg;
    endtask

    task automatic t_start(bit rep, int s);
        snap();
        run_cmd(C_START, s);
        if (rep) begin
            chk("R9 repeated start low", m_lo, x_lo());
            chk("R9 repeated start high", m_hi, 2 * x_hi() + s);
            chk("R9 repeated start cond", m_cond, x_hi());
        end else begin
            chk("R8 start low", m_lo, 0);
            chk("R8 start high", m_hi, x_hi() + s);
            chk("R8 start cond", m_cond, x_hi() + s);
        end
        chk("R8 scl held after start", int'(scl_out), 0);
    endtask

    task automatic t_bit(int s);
        run_cmd(C_BIT, s);
        chk("R4 bit low length", m_lo, x_lo());
        chk("R5 R6 drive index", m_drv_idx, x_hd());
        chk("R5 drive count", m_drv_n, 1);
        chk("R7 bit high length", m_hi, x_hi() + s);
        chk("R7 sample index", m_smp_idx, s);
        chk("R7 sample count", m_smp_n, 1);
        chk("R4 no cond in bit", m_cond, 0);
        chk("R4 scl low after bit", int'(scl_out), 0);
    endtask

    task automatic t_stop(int s);
        run_cmd(C_STOP, s);
        chk("R10 stop low", m_lo, x_lo());
        chk("R10 stop high", m_hi, x_su() + s);
        chk("R10 stop cond", m_cond, x_lo() + x_su() + s);
        chk("R10 bus free after stop", int'(scl_out), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd7311);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        // R1 reset state with enable low
        chk("R1 scl released", int'(scl_out), 1);
        chk("R1 no cond", int'(sda_cond_low), 0);
        chk("R1 no strobes", int'(drive_stb | sample_stb), 0);
        chk("R1 not ready while disabled", int'(cmd_ready), 0);
        enable = 1'b1;
        step();
        chk("R1 ready once enabled", int'(cmd_ready), 1);

        // R12 bit while bus free is ignored
        run_cmd(C_BIT, 0);
        chk("R12 ignored bit low", m_lo, 0);
        chk("R12 ignored bit high", m_hi, 0);
        chk("R12 scl stays released", int'(scl_out), 1);

        // R2 standard pair, hold enabled
        speed_sel = 2'b01; hold_cfg = 9'h103; setup_cfg = 8'd5;
        t_start(0, 0); t_bit(0); t_bit(3); t_stop(2);
        t_start(0, 4); t_bit(1); t_stop(0);

        // R2 fast pair
        speed_sel = 2'b10; fast_high = 16'd9; fast_low = 16'd14;
        t_start(0, 0); t_bit(2); t_stop(0);

        // R3 floors, R5 hold disabled, R10 setup zero
        speed_sel = 2'b00; std_high = 16'd2; std_low = 16'd3; hold_cfg = 9'h0ff; setup_cfg = 8'd0;
        t_start(0, 0);
        chk("R3 high floor", m_hi, 6);
        t_bit(0);
        chk("R3 low floor", m_lo, 8);
        chk("R5 hold disabled drive at 0", m_drv_idx, 0);
        t_stop(0);
        chk("R10 setup zero as one", m_hi, 1);

        // R6 clamp of a large hold
        std_high = 16'd7; std_low = 16'd10; hold_cfg = 9'h114; setup_cfg = 8'd6;
        t_start(0, 0); t_bit(0);
        chk("R6 clamped drive", m_drv_idx, 4);
        // R9 repeated start, R12 no-op while held
        t_start(1, 2);
        run_cmd(C_NONE, 0);
        chk("R12 no-op keeps scl low", int'(scl_out), 0);
        chk("R12 no-op no phases", m_lo + m_hi, 0);
        t_bit(0);
        // R11 change after START has no effect
        std_low = 16'd25; hold_cfg = 9'h000;
        t_bit(0);
        chk("R11 old low kept", m_lo, 10);
        t_stop(0);
        t_start(0, 0); t_bit(0);
        chk("R11 new low after start", m_lo, 25);

        // R13 disable during a bit
        while (!cmd_ready) step();
        cmd_valid = 1'b1; cmd_op = C_BIT;
        step();
        cmd_valid = 1'b0;
        step();
        enable = 1'b0;
        step();
        chk("R13 scl released on disable", int'(scl_out), 1);
        chk("R13 cond cleared on disable", int'(sda_cond_low), 0);
        enable = 1'b1;
        step();
        run_cmd(C_BIT, 0);
        chk("R13 bus free after disable", m_lo + m_hi, 0);

        // random transfers
        for (int it = 0; it < 30; it++) begin
            speed_sel = 2'($urandom_range(3, 0));
            std_high  = 16'($urandom_range(40, 0));
            std_low   = 16'($urandom_range(40, 0));
            fast_high = 16'($urandom_range(30, 0));
            fast_low  = 16'($urandom_range(30, 0));
            hold_cfg  = {1'($urandom_range(1, 0)), 8'($urandom_range(40, 0))};
            setup_cfg = 8'($urandom_range(20, 0));
            t_start(0, $urandom_range(3, 0));
            for (int b = 0; b < int'($urandom_range(3, 1)); b++) t_bit($urandom_range(5, 0));
            if ($urandom_range(1, 0) == 1) begin
                t_start(1, $urandom_range(3, 0));
                t_bit($urandom_range(2, 0));
            end
            t_stop($urandom_range(4, 0));
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule